// File: doc/BRIEF.md
# Strided Vector Load Unit over Interleaved Memory Banks

This block fills one vector register from a word memory interleaved across sixteen banks. A command names a base word address, a stride, a destination vector register and an element count. Element i is fetched from address base + i*stride. The unit emits at most one bank request per cycle, always in element order. Read data comes back on a fixed-latency return path and is written, unchanged, into the destination register at the element's index.

A bank that has just been accessed stays occupied for a whole bank cycle of four processor cycles. When the next element maps to an occupied bank, issue stops until that bank frees, and no later element may pass it. The stride therefore sets the throughput. Stride 1 spreads the elements over all banks and sustains one element per cycle. Strides 0 and 16 land every element on one bank and give one element every four cycles. Stride 8 alternates between two banks and gives two elements every four cycles. A read port lets the surrounding datapath read any element of any vector register.

The control is a four-state machine:
- IDLE: the unit waits for a command. Transition ACCEPT goes to ISSUE, or transition EMPTY goes to FINISH when the count is zero.
- ISSUE: requests are sent. Transition LAST_ISSUED goes to DRAIN.
- DRAIN: the unit waits for outstanding returns. Transition LAST_WRITTEN goes to FINISH.
- FINISH: done is raised for one cycle. Transition RELEASE goes back to IDLE.

Top module: `vld_strided_load`

## Requirements
- R1: The request for element i carries word address base + i*stride, computed modulo 2^24. The bank is `mem_req_bank` = address bits [3:0], and the row is `mem_req_row` = address bits [23:4]. Requests appear in increasing element order.
- R2: At most one request is made per cycle. The first request is made in the cycle after the command is accepted. A request is made in every ISSUE cycle in which the next element's bank is free.
- R3: After a bank receives a request, it receives no other request in the following three cycles.
- R4: When the next element's bank is occupied, issue waits for it. No later element is requested first.
- R5: Element i's 72-bit word is the `mem_rsp_data` value present in the fourth cycle after element i's request cycle. It is written unchanged to element i of register `cmd_vd`.
- R6: Elements at index ≥ count in the destination register, and all other vector registers, keep their contents.
- R7: A `cmd_len` above 64 is treated as 64. A `cmd_len` of 0 makes no request and raises done in the cycle after acceptance.
- R8: `done` is high for exactly one cycle: the cycle right after the clock edge that writes the last element. `ready` is high only in IDLE. A `start` while `ready` is low is ignored.
- R9: During and right after reset, `ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R10: With stride 1, the unit issues one element per cycle. With stride 0, it issues one element every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when ready is high |
| cmd_base | input | 24 | Base word address |
| cmd_stride | input | 24 | Stride in words, two's complement |
| cmd_vd | input | 3 | Destination vector register |
| cmd_len | input | 8 | Element count (values above 64 are treated as 64) |
| ready | output | 1 | High in IDLE |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | A bank request is made this cycle |
| mem_req_bank | output | 4 | Bank index of the request |
| mem_req_row | output | 20 | Row within the bank |
| mem_rsp_data | input | 72 | Read word, due four cycles after its request |
| rd_vreg | input | 3 | Read port register select |
| rd_elem | input | 6 | Read port element select |
| rd_data | output | 72 | Read port word |

## Verification
A busy counter that frees too early shows at the ports at once: two requests to one bank land less than four cycles apart. A counter that frees too late stretches the issue schedule, so the done pulse arrives later than the stride predicts. A wrong address step or element count shows on the very next request, or as a wrong number of requests. A return tag that is off by one stage writes neighbouring words into the wrong slots. This appears when the register is read back after done. The bench predicts the exact request cycle of every element from a bank-occupancy model and compares the done cycle against it.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } vld_state_e;

endpackage

// File: rtl/vld_addr_gen.sv
// Running element address: loads the base, then adds the stride once per issued element.
module vld_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            count_o <= '0;
        end else if (load) begin
            addr_o  <= base_i;
            count_o <= '0;
        end else if (advance) begin
            addr_o  <= addr_o + stride_i;
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/vld_bank_tracker.sv
// One occupancy counter per bank; a bank is free when its counter is zero.
module vld_bank_tracker #(
    parameter int NUM_BANKS   = 16,
    parameter int BANK_CYCLES = 4,
    parameter int BANK_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [BANK_W-1:0] bank_i,
    output logic              bank_free_o
);

    localparam int BUSY_W = $clog2(BANK_CYCLES + 1);

    logic [NUM_BANKS-1:0] free_vec;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [BUSY_W-1:0] busy_cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy_cnt <= '0;
            end else if (issue && (bank_i == BANK_W'(g))) begin
                busy_cnt <= BUSY_W'(BANK_CYCLES - 1);
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - BUSY_W'(1);
            end
        end

        assign free_vec[g] = (busy_cnt == '0);
    end

    assign bank_free_o = free_vec[bank_i];

endmodule

// File: rtl/vld_return_pipe.sv
// Carries each issued element's index alongside the fixed memory latency.
module vld_return_pipe #(
    parameter int LAT   = 4,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_idx
);

    logic [LAT-1:0]   vld_q;
    logic [IDX_W-1:0] idx_q [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    idx_q[0] <= '0;
                end else begin
                    vld_q[0] <= push;
                    idx_q[0] <= push_idx;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    idx_q[g] <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    idx_q[g] <= idx_q[g-1];
                end
            end
        end
    end

    assign wr_valid = vld_q[LAT-1];
    assign wr_idx   = idx_q[LAT-1];

endmodule

// File: rtl/vld_vreg_file.sv
// Vector register storage: one write port, one combinational read port.
// NUM_VREGS and MAX_VL are powers of two.
module vld_vreg_file #(
    parameter int WORD_W = 72,
    parameter int VREG_W = 3,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [VREG_W-1:0] wr_reg,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [VREG_W-1:0] rd_reg,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << (VREG_W + IDX_W);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[{wr_reg, wr_idx}] <= wr_data;
        end
    end

    assign rd_data = store_q[{rd_reg, rd_idx}];

endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load
    import vld_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int WORD_W      = 72,
    parameter int NUM_BANKS   = 16,
    parameter int BANK_CYCLES = 4,
    parameter int RET_LAT     = 4,
    parameter int MAX_VL      = 64,
    parameter int NUM_VREGS   = 8,
    parameter int LEN_W       = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [ADDR_W-1:0]                      cmd_base,
    input  logic [ADDR_W-1:0]                      cmd_stride,
    input  logic [$clog2(NUM_VREGS)-1:0]           cmd_vd,
    input  logic [LEN_W-1:0]                       cmd_len,
    output logic                                   ready,
    output logic                                   done,
    output logic                                   mem_req_valid,
    output logic [$clog2(NUM_BANKS)-1:0]           mem_req_bank,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]    mem_req_row,
    input  logic [WORD_W-1:0]                      mem_rsp_data,
    input  logic [$clog2(NUM_VREGS)-1:0]           rd_vreg,
    input  logic [$clog2(MAX_VL)-1:0]              rd_elem,
    output logic [WORD_W-1:0]                      rd_data
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int VREG_W = $clog2(NUM_VREGS);
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int CNT_W  = $clog2(MAX_VL + 1);

    vld_state_e          state_q, state_d;
    logic [VREG_W-1:0]   vd_q;
    logic [CNT_W-1:0]    len_q;
    logic [ADDR_W-1:0]   stride_q;
    logic [CNT_W-1:0]    len_eff;
    logic                accept;
    logic [ADDR_W-1:0]   cur_addr;
    logic [CNT_W-1:0]    issued_cnt;
    logic                bank_free;
    logic                issue_fire;
    logic                last_issue;
    logic                wr_valid;
    logic [IDX_W-1:0]    wr_idx;
    logic                last_write;

    // Count clamp
    always_comb begin
        if (cmd_len > LEN_W'(MAX_VL)) begin
            len_eff = CNT_W'(MAX_VL);
        end else begin
            len_eff = cmd_len[CNT_W-1:0];
        end
    end

    assign accept     = (state_q == ST_IDLE) && start;
    assign issue_fire = (state_q == ST_ISSUE) && bank_free;
    assign last_issue = issue_fire && (issued_cnt == len_q - CNT_W'(1));
    assign last_write = wr_valid && (CNT_W'(wr_idx) == len_q - CNT_W'(1));

    // Command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q     <= '0;
            len_q    <= '0;
            stride_q <= '0;
        end else if (accept) begin
            vd_q     <= cmd_vd;
            len_q    <= len_eff;
            stride_q <= cmd_stride;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ACCEPT, EMPTY, LAST_ISSUED, LAST_WRITTEN, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (len_eff == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (last_issue) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (last_write) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        ready         = (state_q == ST_IDLE);
        done          = (state_q == ST_FINISH);
        mem_req_valid = issue_fire;
        mem_req_bank  = cur_addr[BANK_W-1:0];
        mem_req_row   = cur_addr[ADDR_W-1:BANK_W];
    end

    vld_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .base_i   (cmd_base),
        .stride_i (stride_q),
        .advance  (issue_fire),
        .addr_o   (cur_addr),
        .count_o  (issued_cnt)
    );

    vld_bank_tracker #(
        .NUM_BANKS   (NUM_BANKS),
        .BANK_CYCLES (BANK_CYCLES),
        .BANK_W      (BANK_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue_fire),
        .bank_i      (cur_addr[BANK_W-1:0]),
        .bank_free_o (bank_free)
    );

    vld_return_pipe #(
        .LAT   (RET_LAT),
        .IDX_W (IDX_W)
    ) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (issue_fire),
        .push_idx (issued_cnt[IDX_W-1:0]),
        .wr_valid (wr_valid),
        .wr_idx   (wr_idx)
    );

    vld_vreg_file #(
        .WORD_W (WORD_W),
        .VREG_W (VREG_W),
        .IDX_W  (IDX_W)
    ) u_vrf (
        .clk     (clk),
        .we      (wr_valid),
        .wr_reg  (vd_q),
        .wr_idx  (wr_idx),
        .wr_data (mem_rsp_data),
        .rd_reg  (rd_vreg),
        .rd_idx  (rd_elem),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/vld_strided_load_chk.sv
module vld_strided_load_chk #(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ready,
    input logic                     done,
    input logic                     mem_req_valid,
    input logic [BANK_W-1:0]        mem_req_bank,
    input logic [ADDR_W-BANK_W-1:0] mem_req_row,
    input logic [ADDR_W-1:0]        stride_q
);

    // R1: back-to-back requests step by the latched stride
    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid)) |->
        ({mem_req_row, mem_req_bank} == $past({mem_req_row, mem_req_bank}) + stride_q));

    // R3: a bank sees no second request within three cycles
    assert_bank_gap1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid, 1)) |-> (mem_req_bank != $past(mem_req_bank, 1)));
    assert_bank_gap2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid, 2)) |-> (mem_req_bank != $past(mem_req_bank, 2)));
    assert_bank_gap3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid, 3)) |-> (mem_req_bank != $past(mem_req_bank, 3)));

    // R8: done lasts one cycle and returns to idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

    // R9: no request while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !mem_req_valid);

endmodule

bind vld_strided_load vld_strided_load_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready         (ready),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_bank  (mem_req_bank),
    .mem_req_row   (mem_req_row),
    .stride_q      (stride_q)
);

// File: tb/vld_strided_load_tb_top.sv
`timescale 1ns/1ps
module vld_strided_load_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] cmd_base = '0;
    logic [23:0] cmd_stride = '0;
    logic [2:0]  cmd_vd = '0;
    logic [7:0]  cmd_len = '0;
    logic        ready, done, mem_req_valid;
    logic [3:0]  mem_req_bank;
    logic [19:0] mem_req_row;
    logic [71:0] mem_rsp_data = '0;
    logic [2:0]  rd_vreg = '0;
    logic [5:0]  rd_elem = '0;
    logic [71:0] rd_data;

    int checks = 0;
    int errors = 0;
    int pc = 0;
    int s_cyc = 0;
    int n_obs = 0;
    int done_cnt = 0;
    int done_cyc = -1;
    int obs_cyc [128];
    logic [23:0] obs_addr [128];
    logic        hv [5];
    logic [23:0] ha [5];
    logic [71:0] shadow [8][64];
    bit          sh_ok [8][64];

    localparam logic [23:0] T_BASE   [6] = '{24'd100, 24'h000040, 24'd7, 24'd3, 24'h00FFF0, 24'hFFFFFE};
    localparam logic [23:0] T_STRIDE [6] = '{24'd1, 24'd0, 24'd16, 24'd8, 24'hFFFFFD, 24'd5};
    localparam logic [7:0]  T_LEN    [6] = '{8'd16, 8'd6, 8'd5, 8'd10, 8'd12, 8'd64};
    localparam logic [2:0]  T_VD     [6] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd6};

    vld_strided_load dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_base(cmd_base),
        .cmd_stride(cmd_stride), .cmd_vd(cmd_vd), .cmd_len(cmd_len),
        .ready(ready), .done(done), .mem_req_valid(mem_req_valid),
        .mem_req_bank(mem_req_bank), .mem_req_row(mem_req_row),
        .mem_rsp_data(mem_rsp_data), .rd_vreg(rd_vreg), .rd_elem(rd_elem),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) pc <= pc + 1;

    function automatic logic [71:0] word_of(input logic [23:0] a);
        return {a[7:0] ^ 8'h3C, 40'hC0FFEE1234, a};
    endfunction

    // Memory model and port monitor, sampled at the falling edge
    always @(negedge clk) begin
        for (int k = 4; k > 0; k--) begin
            hv[k] = hv[k-1];
            ha[k] = ha[k-1];
        end
        hv[0] = (rst_n === 1'b1) && (mem_req_valid === 1'b1);
        ha[0] = {mem_req_row, mem_req_bank};
        mem_rsp_data <= (hv[4] === 1'b1) ? word_of(ha[4]) : 72'h0;
        if (hv[0] && n_obs < 128) begin
            obs_addr[n_obs] = ha[0];
            obs_cyc[n_obs]  = pc - s_cyc;
            n_obs++;
        end
        if (rst_n === 1'b1 && done === 1'b1) begin
            done_cnt++;
            done_cyc = pc - s_cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_shadow(input string req);
        int bad = 0;
        for (int r = 0; r < 8; r++) begin
            for (int e = 0; e < 64; e++) begin
                if (sh_ok[r][e]) begin
                    rd_vreg = 3'(r);
                    rd_elem = 6'(e);
                    #1;
                    if (rd_data !== shadow[r][e]) bad++;
                end
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Runs one command and checks requests, timing and done; returns the done cycle
    task automatic run_cmd(input logic [23:0] base, input logic [23:0] stride,
                           input logic [7:0] len, input logic [2:0] vd,
                           input bit stray, output int dcyc);
        int n_eff;
        int nf [16];
        int t;
        int last;
        int bad;
        int exp_c [64];
        logic [23:0] exp_a [64];
        logic [23:0] a;
        n_eff = (len > 8'd64) ? 64 : int'(len);
        for (int b = 0; b < 16; b++) nf[b] = 0;
        t = 1;
        last = 0;
        for (int i = 0; i < n_eff; i++) begin
            a = base + 24'(i) * stride;
            exp_a[i] = a;
            exp_c[i] = (t > nf[a[3:0]]) ? t : nf[a[3:0]];
            nf[a[3:0]] = exp_c[i] + 4;
            t = exp_c[i] + 1;
            last = exp_c[i];
        end
        @(posedge clk); #1;
        n_obs = 0; done_cnt = 0; done_cyc = -1; s_cyc = pc;
        cmd_base = base; cmd_stride = stride; cmd_len = len; cmd_vd = vd; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (stray) begin
            cmd_base = 24'h000777; cmd_stride = 24'd2; cmd_len = 8'd3; cmd_vd = 3'd0;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        for (int g = 0; g < 1000 && done_cnt == 0; g++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(n_obs == n_eff, "R7 request count", n_obs, n_eff);
        bad = 0;
        for (int i = 0; i < n_eff && i < n_obs; i++) begin
            if (obs_addr[i] !== exp_a[i] || obs_cyc[i] != exp_c[i]) bad++;
        end
        chk(bad == 0, "R1 R2 R3 R4 request address and cycle", bad, 0);
        dcyc = (n_eff == 0) ? 1 : last + 5;
        chk(done_cyc == dcyc, "R8 done cycle", done_cyc, dcyc);
        chk(done_cnt == 1, "R8 done width", done_cnt, 1);
        for (int i = 0; i < n_eff; i++) begin
            shadow[vd][i] = word_of(exp_a[i]);
            sh_ok[vd][i] = 1'b1;
        end
        check_shadow("R5 R6 register contents");
    endtask

    initial begin
        int dc;
        int bad;
        logic [71:0] keep [64];
        for (int r = 0; r < 8; r++)
            for (int e = 0; e < 64; e++) sh_ok[r][e] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            hv[k] = 1'b0;
            ha[k] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(ready === 1'b1, "R9 ready in reset", ready, 1);
        chk(done === 1'b0, "R9 done in reset", done, 0);
        chk(mem_req_valid === 1'b0, "R9 no request in reset", mem_req_valid, 0);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(ready === 1'b1 && done === 1'b0 && mem_req_valid === 1'b0,
            "R9 idle after reset", {ready, done, mem_req_valid}, 3'b100);

        for (int k = 0; k < 6; k++) begin
            run_cmd(T_BASE[k], T_STRIDE[k], T_LEN[k], T_VD[k], 1'b0, dc);
            if (k == 0) chk(dc == 21, "R10 stride 1 one per cycle", dc, 21);
            if (k == 1) chk(dc == 26, "R10 stride 0 one per four", dc, 26);
        end

        // R7: zero count
        run_cmd(24'h000123, 24'd1, 8'd0, 3'd7, 1'b0, dc);
        // R7: count above the maximum is clamped
        run_cmd(24'h000200, 24'd2, 8'd100, 3'd2, 1'b0, dc);
        for (int e = 0; e < 64; e++) keep[e] = shadow[2][e];
        // R6: a short load leaves the tail of its register alone
        run_cmd(24'h000900, 24'd3, 8'd5, 3'd2, 1'b0, dc);
        bad = 0;
        for (int e = 5; e < 64; e++) begin
            rd_vreg = 3'd2;
            rd_elem = 6'(e);
            #1;
            if (rd_data !== keep[e]) bad++;
        end
        chk(bad == 0, "R6 tail elements kept", bad, 0);
        // R8: start while busy is ignored (stray command aims at register 0)
        run_cmd(24'h004000, 24'd1, 8'd16, 3'd3, 1'b1, dc);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule